// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block sits in a bridge and decides whether a downstream memory address belongs to one of two address windows. One window is for non-prefetchable memory, such as control and status registers. The other is for prefetchable memory, such as large local buffers. Each window is set by a base register and a limit register. Both registers hold only the upper twelve address bits, so a window always covers whole 1 MiB blocks. The base block is taken from its lowest byte and the limit block up to its highest byte.

Software programs the four registers through a small register port with one byte enable per lane. The lowest nibble of every register is read-only. On the prefetchable pair that nibble reports whether upper-address extension is available. A decode port accepts an address together with a request strobe. One cycle later it returns a registered result: whether the address hit, which window it hit, and an overlap flag for addresses that both windows claim. The block does not check whether the two windows overlap; keeping them exclusive is the job of software.

Top module: `bwin_decoder`

## Requirements
- R1: After reset, all four registers read 0000h in their upper twelve bits, and hit_valid_o, hit_o, hit_pref_o and overlap_o are all 0.
- R2: A write with cfg_be_i[1] set updates bits [15:8] from cfg_wdata_i. A write with cfg_be_i[0] set updates bits [7:4]. A lane whose enable is clear keeps its old value.
- R3: On the non-prefetchable registers (index 0 and 1), bits [3:0] always read 0, whatever value is written to them.
- R4: On the prefetchable registers (index 2 and 3), bits [3:0] always read the capability code. The code is 1h when the parameter ADDR64 is 1, which is the default, and 0h when ADDR64 is 0. Writes to these bits are ignored.
- R5: The register index map is fixed: 0 is the non-prefetchable base, 1 the non-prefetchable limit, 2 the prefetchable base and 3 the prefetchable limit.
- R6: hit_valid_o is 1 exactly in the cycle after a cycle in which req_i was sampled as 1. hit_o, hit_pref_o and overlap_o are 0 whenever hit_valid_o is 0.
- R7: An address lies in a window when it is at least {base[15:4], 20'h00000} and at most {limit[15:4], 20'hFFFFF}. Both ends of the window are inclusive.
- R8: A window whose base[15:4] is greater than its limit[15:4] claims no address.
- R9: A hit in the prefetchable window alone gives hit_o=1 and hit_pref_o=1. A hit in the non-prefetchable window gives hit_o=1 and hit_pref_o=0. A miss gives hit_o=0.
- R10: When both windows claim the address, the result is hit_o=1, hit_pref_o=0 and overlap_o=1. In all other cases overlap_o is 0.
- R11: A register write acts on decode requests sampled at the next clock edge after the write. A request sampled at the same edge as the write still sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 2 | Register index |
| cfg_be_i | input | 2 | Byte enables for the write |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Read data of the indexed register (combinational) |
| req_i | input | 1 | Decode request strobe |
| addr_i | input | 32 | Address to decode |
| hit_valid_o | output | 1 | Decode result valid, one cycle after the request |
| hit_o | output | 1 | The address falls inside a window |
| hit_pref_o | output | 1 | The hit is in the prefetchable window |
| overlap_o | output | 1 | Both windows claimed the address |

## Verification
The assertions check on every cycle that the result follows the request strobe by exactly one cycle. They also check that the hit, window and overlap flags stay low without a valid result, that an overlap is always reported as a non-prefetchable hit, that non-prefetchable registers read a zero low nibble, and that stored register bits change only after a write. The bench scenarios show the things a property cannot: the exact inclusive window edges at 1 MiB granularity, inverted windows that claim nothing, the byte-lane merge, and a write that races a decode in the same cycle.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  typedef enum logic [1:0] {
    REG_MEM_BASE  = 2'd0,
    REG_MEM_LIMIT = 2'd1,
    REG_PF_BASE   = 2'd2,
    REG_PF_LIMIT  = 2'd3
  } reg_idx_e;

  localparam int NUM_WIN = 2;
  localparam int WIN_MEM = 0;
  localparam int WIN_PF  = 1;

  localparam logic [3:0] CAP_32 = 4'h0;
  localparam logic [3:0] CAP_64 = 4'h1;
endpackage

// File: rtl/bwin_regs.sv
module bwin_regs
  import bwin_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int RO_W  = 4,
  parameter int NREG  = 4,
  parameter int IDX_W = 2,
  parameter logic [RO_W-1:0] CAP_CODE = '0,
  localparam int HI_W = REG_W - RO_W,
  localparam int NBE  = REG_W / 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [NBE-1:0]             be_i,
  input  logic [REG_W-1:0]           wdata_i,
  output logic [REG_W-1:0]           rdata_o,
  output logic [NREG-1:0][HI_W-1:0]  hi_o
);
  logic [NREG-1:0][HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
    end else if (we_i) begin
      for (int b = 0; b < HI_W; b++) begin
        if (be_i[(b + RO_W) / 8]) hi_q[idx_i][b] <= wdata_i[b + RO_W];
      end
    end
  end

  logic ro_pref;
  assign ro_pref = (idx_i >= IDX_W'(REG_PF_BASE));
  assign rdata_o = {hi_q[idx_i], ro_pref ? CAP_CODE : {RO_W{1'b0}}};
  assign hi_o    = hi_q;

  // R2: stored bits move only after a write strobe
  a_r2_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> $stable(hi_q));
endmodule

// File: rtl/bwin_window.sv
module bwin_window #(
  parameter int HI_W = 12
) (
  input  logic [HI_W-1:0] base_i,
  input  logic [HI_W-1:0] limit_i,
  input  logic [HI_W-1:0] addr_hi_i,
  output logic            hit_o
);
  logic active;
  // base/limit in 1 MiB units; low 20 bits implied 0 / FFFFF
  assign active = (base_i <= limit_i);
  assign hit_o  = active && (addr_hi_i >= base_i) && (addr_hi_i <= limit_i);
endmodule

// File: rtl/bwin_decoder.sv
module bwin_decoder
  import bwin_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 20,
  parameter int REG_W  = 16,
  parameter bit ADDR64 = 1'b1,
  localparam int RO_W  = 4,
  localparam int NREG  = 2 * NUM_WIN,
  localparam int IDX_W = $clog2(NREG),
  localparam int HI_W  = ADDR_W - GRAN_W,
  localparam int NBE   = REG_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [NBE-1:0]    cfg_be_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_valid_o,
  output logic              hit_o,
  output logic              hit_pref_o,
  output logic              overlap_o
);
  localparam logic [RO_W-1:0] CAP_CODE = ADDR64 ? CAP_64 : CAP_32;

  logic [NREG-1:0][HI_W-1:0] reg_hi;
  logic [NUM_WIN-1:0]        win_hit;

  bwin_regs #(
    .REG_W(REG_W), .RO_W(RO_W), .NREG(NREG), .IDX_W(IDX_W), .CAP_CODE(CAP_CODE)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .hi_o    (reg_hi)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    bwin_window #(.HI_W(HI_W)) u_win (
      .base_i    (reg_hi[2*g]),
      .limit_i   (reg_hi[2*g+1]),
      .addr_hi_i (addr_i[ADDR_W-1:GRAN_W]),
      .hit_o     (win_hit[g])
    );
  end

  logic valid_q, hit_q, pref_q, ovl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      pref_q  <= 1'b0;
      ovl_q   <= 1'b0;
    end else begin
      valid_q <= req_i;
      hit_q   <= req_i && (|win_hit);
      // non-prefetchable wins on overlap
      pref_q  <= req_i && win_hit[WIN_PF] && !win_hit[WIN_MEM];
      ovl_q   <= req_i && (&win_hit);
    end
  end

  assign hit_valid_o = valid_q;
  assign hit_o       = hit_q;
  assign hit_pref_o  = pref_q;
  assign overlap_o   = ovl_q;

  a_r6_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> hit_valid_o);
  a_r6_idle_without_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !hit_valid_o);
  a_r6_flags_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_valid_o |-> !(hit_o || hit_pref_o || overlap_o));
  a_r10_overlap_is_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overlap_o |-> (hit_o && !hit_pref_o));
  a_r9_pref_implies_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_pref_o |-> hit_o);
  a_r3_mem_nibble_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_idx_i < IDX_W'(REG_PF_BASE)) |-> (cfg_rdata_o[RO_W-1:0] == '0));
endmodule

// File: tb/bwin_decoder_tb.sv
module bwin_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [1:0]  cfg_be = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        hit_valid, hit, hit_pref, overlap;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bwin_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_be_i(cfg_be),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_i(req), .addr_i(addr),
    .hit_valid_o(hit_valid), .hit_o(hit), .hit_pref_o(hit_pref), .overlap_o(overlap)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] idx, input logic [15:0] exp);
    cfg_idx = idx;
    #1;
    chk(tag, {16'h0, cfg_rdata}, {16'h0, exp});
  endtask

  // returns {valid, hit, pref, overlap}
  task automatic dec(input logic [31:0] a, output logic [3:0] res);
    @(negedge clk);
    req = 1'b1; addr = a;
    @(negedge clk);
    req = 1'b0;
    res = {hit_valid, hit, hit_pref, overlap};
  endtask

  task automatic t_reset;
    chk("R1 valid at reset", {28'h0, hit_valid, hit, hit_pref, overlap}, 32'h0);
    rd_chk("R1 R5 mem base reset", 2'd0, 16'h0000);
    rd_chk("R1 R5 mem limit reset", 2'd1, 16'h0000);
    rd_chk("R1 R4 pf base reset", 2'd2, 16'h0001);
    rd_chk("R1 R4 pf limit reset", 2'd3, 16'h0001);
  endtask

  task automatic t_lanes;
    wr(2'd0, 2'b10, 16'hABCD);
    rd_chk("R2 upper lane only", 2'd0, 16'hAB00);
    wr(2'd0, 2'b01, 16'h12F7);
    rd_chk("R2 R3 lower lane only", 2'd0, 16'hABF0);
    wr(2'd2, 2'b11, 16'hFFFF);
    rd_chk("R4 pf nibble ignores write", 2'd2, 16'hFFF1);
    wr(2'd1, 2'b11, 16'h345F);
    rd_chk("R3 R5 mem limit nibble", 2'd1, 16'h3450);
  endtask

  task automatic t_mem;
    logic [3:0] r;
    wr(2'd0, 2'b11, 16'h1000);
    wr(2'd1, 2'b11, 16'h10F0);
    wr(2'd2, 2'b11, 16'hFFF0);
    wr(2'd3, 2'b11, 16'h0000);
    dec(32'h1000_0000, r); chk("R7 R9 mem low edge", {28'h0, r}, 32'hC);
    dec(32'h10FF_FFFF, r); chk("R7 mem high edge", {28'h0, r}, 32'hC);
    dec(32'h0FFF_FFFF, r); chk("R7 below base", {28'h0, r}, 32'h8);
    dec(32'h1100_0000, r); chk("R7 above limit", {28'h0, r}, 32'h8);
    @(negedge clk);
    chk("R6 idle after result", {28'h0, hit_valid, hit, hit_pref, overlap}, 32'h0);
  endtask

  task automatic t_pref;
    logic [3:0] r;
    wr(2'd2, 2'b11, 16'h2000);
    wr(2'd3, 2'b11, 16'h2000);
    dec(32'h200A_BCDE, r); chk("R9 pf single block", {28'h0, r}, 32'hE);
    dec(32'h2010_0000, r); chk("R7 pf past block", {28'h0, r}, 32'h8);
  endtask

  task automatic t_inactive;
    logic [3:0] r;
    wr(2'd0, 2'b11, 16'h3000);
    wr(2'd1, 2'b11, 16'h2FF0);
    dec(32'h2FF0_0000, r); chk("R8 inverted at limit", {28'h0, r}, 32'h8);
    dec(32'h3000_0000, r); chk("R8 inverted at base", {28'h0, r}, 32'h8);
  endtask

  task automatic t_overlap;
    logic [3:0] r;
    wr(2'd0, 2'b11, 16'h4000);
    wr(2'd1, 2'b11, 16'h4000);
    wr(2'd2, 2'b11, 16'h4000);
    wr(2'd3, 2'b11, 16'h40F0);
    dec(32'h4000_0000, r); chk("R10 both windows", {28'h0, r}, 32'hD);
    dec(32'h4050_0000, r); chk("R10 pf only no overlap", {28'h0, r}, 32'hE);
  endtask

  task automatic t_race;
    logic [3:0] r;
    wr(2'd0, 2'b11, 16'h5000);
    wr(2'd1, 2'b11, 16'h5000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_be = 2'b11; cfg_wdata = 16'h6000;
    req = 1'b1; addr = 32'h5000_0000;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0; req = 1'b0;
    chk("R11 same-edge sees old", {28'h0, hit_valid, hit, hit_pref, overlap}, 32'hC);
    dec(32'h5000_0000, r); chk("R11 next edge sees new", {28'h0, r}, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lanes();
    t_mem();
    t_pref();
    t_inactive();
    t_overlap();
    t_race();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule